// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block sequences a bus transceiver node through three operating modes: sleep, fail-safe and normal. It takes a power-present bit and a supply-undervoltage bit from analog comparators (modelled here as plain digital inputs), the host's enable pin and transmit level, and one-cycle strobes from already-qualified local and remote wake detectors. From these it drives the mode code and several controls: transmitter enable, bus termination enable and an inhibit output that switches an external regulator.

After power-up, a wake or an undervoltage, the controller always lands in fail-safe mode. Communication stays off until the host confirms by holding enable high for a programmed number of cycles. After a wake, the controller raises a wake-request flag meant for the receive pin. It also reports whether the wake came from the local input or from the bus, for the transmit pin. Both indications drop the moment enable goes high. The host puts the node to sleep by pulling enable low while the transmit level is high. A floating enable reads low, so a disconnected host also sends the node to sleep. All mode-change delays are parameters counted in clock cycles.

Top module: `xmc_mode_ctrl`

## Requirements
- R1: Reset leaves the controller in fail-safe mode, with communication off and the wake flag clear.
- R2: While the power-present bit is low, the mode is forced to fail-safe and inhibit, termination, communication and wake flags are all off. Inhibit stays off until INH_DLY clock edges have passed with power present, and is then allowed.
- R3: Undervoltage moves any mode to fail-safe at the next edge. It turns communication enable off in the same cycle it is seen. It keeps inhibit off while it lasts in fail-safe. It prevents entry into normal mode.
- R4: In fail-safe mode, enable held high for NORM_DLY consecutive edges without undervoltage enters normal mode at the last of those edges. Enable dropping earlier restarts the count.
- R5: In normal mode, a sleep request is armed once enable is low while transmit is high. It stays armed even if transmit then drops. Sleep mode is entered after SLEEP_DLY consecutive edges with enable low. Enable low with transmit low and no arm keeps normal mode. Enable returning high cancels the request.
- R6: In sleep mode, a local or remote wake strobe moves to fail-safe at the next edge. Enable going high while in sleep mode has no effect.
- R7: Communication enable is on only in normal mode. Termination enable is on in normal and fail-safe modes and off in sleep. Inhibit is off in sleep.
- R8: A wake from sleep sets a wake-request flag. The flag stays set across edges while enable is low, and clears in the same cycle enable goes high.
- R9: The wake-source output is 1 for a local wake and 0 for a remote wake, and reads 0 whenever the wake flag is clear. When both strobes arrive together with LOCAL_FIRST=1, the source is reported as local.
- R10: The mode output is a 2-bit code: 2'b00 sleep, 2'b01 fail-safe, 2'b10 normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply above the power-up level |
| supply_uv | input | 1 | Supply below the undervoltage level |
| en_pin | input | 1 | Host enable, low when disconnected |
| tx_level | input | 1 | Host transmit level (1 = recessive) |
| wake_loc_stb | input | 1 | Qualified local wake strobe |
| wake_rem_stb | input | 1 | Qualified remote (bus) wake strobe |
| mode | output | 2 | Mode code per R10 |
| comm_en | output | 1 | Transmit/receive path enable |
| term_en | output | 1 | Bus termination enable |
| inh_on | output | 1 | Regulator inhibit switch on |
| rx_wake_flag | output | 1 | Wake-request flag for the receive pin |
| tx_src_local | output | 1 | Wake source for the transmit pin: 1 local, 0 remote |

## Verification
A wrong state register shows at once on the mode code and on the decoded enables. The bench compares these against a mode sequence it derives from the requirements after every stimulus step. A timer that is off by one shows as the mode changing one edge early or late. The bench sweeps every shorter hold length of enable to catch it at the boundary edge. A wake flag that is stuck, or that clears late, shows on the receive and transmit indications either in the same cycle enable rises or on the edges while enable stays low.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
   typedef enum logic [1:0] {
      MD_SLEEP    = 2'b00,
      MD_FAILSAFE = 2'b01,
      MD_NORMAL   = 2'b10
   } xmc_mode_e;
endpackage

// File: rtl/xmc_hold_timer.sv
module xmc_hold_timer #(
   parameter int unsigned HOLD = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   generate
      if (HOLD < 1) begin : g_bad_hold
         initial $fatal(1, "xmc_hold_timer: HOLD must be at least 1");
      end else if (HOLD == 1) begin : g_direct
         assign done = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HOLD);
         localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
         logic [CW-1:0] cnt_q;

         assign done = run && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt_q <= '0;
            else if (!run || done) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end

         AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> (cnt_q == '0)); // R4
         AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST); // R5
      end
   endgenerate
endmodule

// File: rtl/xmc_mode_fsm.sv
module xmc_mode_fsm
   import xmc_pkg::*;
#(
   parameter bit LOCAL_FIRST = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_ok,
   input  logic      supply_uv,
   input  logic      en_pin,
   input  logic      tx_level,
   input  logic      wake_loc_stb,
   input  logic      wake_rem_stb,
   input  logic      norm_done,
   input  logic      sleep_done,
   output xmc_mode_e state,
   output logic      norm_run,
   output logic      sleep_run,
   output logic      flag_q,
   output logic      src_q
);
   xmc_mode_e state_q, state_d;
   logic      arm_q;
   logic      wake_any;
   logic      src_pick;
   logic      live;

   assign live     = pwr_ok && !supply_uv;
   assign wake_any = wake_loc_stb || wake_rem_stb;

   generate
      if (LOCAL_FIRST) begin : g_local_first
         assign src_pick = wake_loc_stb;
      end else begin : g_remote_first
         assign src_pick = wake_loc_stb && !wake_rem_stb;
      end
   endgenerate

   assign norm_run  = live && (state_q == MD_FAILSAFE) && en_pin;
   assign sleep_run = live && (state_q == MD_NORMAL) && !en_pin && (tx_level || arm_q);

   always_comb begin
      state_d = state_q;
      if (!pwr_ok || supply_uv) begin
         state_d = MD_FAILSAFE;
      end else begin
         unique case (state_q)
            MD_FAILSAFE: if (norm_done)  state_d = MD_NORMAL;
            MD_NORMAL:   if (sleep_done) state_d = MD_SLEEP;
            MD_SLEEP:    if (wake_any)   state_d = MD_FAILSAFE;
            default:                     state_d = MD_FAILSAFE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MD_FAILSAFE;
         arm_q   <= 1'b0;
         flag_q  <= 1'b0;
         src_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         arm_q   <= sleep_run;
         if (!pwr_ok) begin
            flag_q <= 1'b0;
            src_q  <= 1'b0;
         end else if (live && (state_q == MD_SLEEP) && wake_any) begin
            flag_q <= 1'b1;
            src_q  <= src_pick;
         end else if (en_pin) begin
            flag_q <= 1'b0;
            src_q  <= 1'b0;
         end
      end
   end

   assign state = state_q;

   AST_UV_TO_FAILSAFE: assert property (@(posedge clk) disable iff (!rst_n)
      supply_uv |=> (state_q == MD_FAILSAFE)); // R3
   AST_WAKE_TO_FAILSAFE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_ok && (state_q == MD_SLEEP) && wake_any) |=> (state_q == MD_FAILSAFE)); // R6
   AST_SLEEP_ONLY_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MD_FAILSAFE) |=> (state_q != MD_SLEEP)); // R5
   AST_NO_NORMAL_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MD_SLEEP) |=> (state_q != MD_NORMAL)); // R6
   AST_UNPOWERED_FAILSAFE: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> ((state_q == MD_FAILSAFE) && !flag_q)); // R2
endmodule

// File: rtl/xmc_out_decode.sv
module xmc_out_decode
   import xmc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  xmc_mode_e  state,
   input  logic       pwr_ok,
   input  logic       supply_uv,
   input  logic       en_pin,
   input  logic       inh_ready,
   input  logic       flag_q,
   input  logic       src_q,
   output logic [1:0] mode,
   output logic       comm_en,
   output logic       term_en,
   output logic       inh_on,
   output logic       rx_wake_flag,
   output logic       tx_src_local
);
   logic in_norm, in_fs;

   assign in_norm      = (state == MD_NORMAL);
   assign in_fs        = (state == MD_FAILSAFE);
   assign mode         = state;
   assign comm_en      = pwr_ok && !supply_uv && in_norm;
   assign term_en      = pwr_ok && (in_norm || in_fs);
   assign inh_on       = pwr_ok && inh_ready && (in_norm || (in_fs && !supply_uv));
   assign rx_wake_flag = flag_q && !en_pin;
   assign tx_src_local = rx_wake_flag && src_q;

   AST_UV_BLOCKS_COMM: assert property (@(posedge clk) disable iff (!rst_n)
      supply_uv |-> !comm_en); // R3
   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> (!inh_on && !term_en && !comm_en)); // R7
   AST_FLAG_DROPS_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
      en_pin |-> (!rx_wake_flag && !tx_src_local)); // R8
   AST_SRC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      tx_src_local |-> rx_wake_flag); // R9
   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11); // R10
endmodule

// File: rtl/xmc_mode_ctrl.sv
module xmc_mode_ctrl
   import xmc_pkg::*;
#(
   parameter int unsigned NORM_DLY    = 100,
   parameter int unsigned SLEEP_DLY   = 200,
   parameter int unsigned INH_DLY     = 5000,
   parameter bit          LOCAL_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_ok,
   input  logic       supply_uv,
   input  logic       en_pin,
   input  logic       tx_level,
   input  logic       wake_loc_stb,
   input  logic       wake_rem_stb,
   output logic [1:0] mode,
   output logic       comm_en,
   output logic       term_en,
   output logic       inh_on,
   output logic       rx_wake_flag,
   output logic       tx_src_local
);
   xmc_mode_e state;
   logic norm_run, norm_done, sleep_run, sleep_done;
   logic inh_run, inh_done, inh_ready_q;
   logic flag_q, src_q;

   xmc_mode_fsm #(.LOCAL_FIRST(LOCAL_FIRST)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .supply_uv(supply_uv),
      .en_pin(en_pin), .tx_level(tx_level),
      .wake_loc_stb(wake_loc_stb), .wake_rem_stb(wake_rem_stb),
      .norm_done(norm_done), .sleep_done(sleep_done),
      .state(state), .norm_run(norm_run), .sleep_run(sleep_run),
      .flag_q(flag_q), .src_q(src_q)
   );

   xmc_hold_timer #(.HOLD(NORM_DLY)) u_norm_tmr (
      .clk(clk), .rst_n(rst_n), .run(norm_run), .done(norm_done)
   );

   xmc_hold_timer #(.HOLD(SLEEP_DLY)) u_sleep_tmr (
      .clk(clk), .rst_n(rst_n), .run(sleep_run), .done(sleep_done)
   );

   assign inh_run = pwr_ok && !inh_ready_q;

   xmc_hold_timer #(.HOLD(INH_DLY)) u_inh_tmr (
      .clk(clk), .rst_n(rst_n), .run(inh_run), .done(inh_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       inh_ready_q <= 1'b0;
      else if (!pwr_ok) inh_ready_q <= 1'b0;
      else if (inh_done) inh_ready_q <= 1'b1;
   end

   xmc_out_decode u_dec (
      .clk(clk), .rst_n(rst_n), .state(state), .pwr_ok(pwr_ok),
      .supply_uv(supply_uv), .en_pin(en_pin), .inh_ready(inh_ready_q),
      .flag_q(flag_q), .src_q(src_q), .mode(mode), .comm_en(comm_en),
      .term_en(term_en), .inh_on(inh_on), .rx_wake_flag(rx_wake_flag),
      .tx_src_local(tx_src_local)
   );

   AST_INH_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> !inh_ready_q); // R2
   AST_NORMAL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 2'b01) && !en_pin) |=> (mode != 2'b10)); // R4
endmodule

// File: tb/xmc_mode_ctrl_bench.sv
module xmc_mode_ctrl_bench;
   localparam int ND = 3;
   localparam int SD = 5;
   localparam int ID = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_ok = 1'b0, supply_uv = 1'b0, en_pin = 1'b0, tx_level = 1'b1;
   logic wake_loc_stb = 1'b0, wake_rem_stb = 1'b0;
   logic [1:0] mode;
   logic comm_en, term_en, inh_on, rx_wake_flag, tx_src_local;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   xmc_mode_ctrl #(.NORM_DLY(ND), .SLEEP_DLY(SD), .INH_DLY(ID), .LOCAL_FIRST(1'b1)) u_xmc_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .supply_uv(supply_uv),
      .en_pin(en_pin), .tx_level(tx_level), .wake_loc_stb(wake_loc_stb),
      .wake_rem_stb(wake_rem_stb), .mode(mode), .comm_en(comm_en),
      .term_en(term_en), .inh_on(inh_on), .rx_wake_flag(rx_wake_flag),
      .tx_src_local(tx_src_local)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic outs(input string req, input int m, input int c, input int t, input int h);
      chk({req, " mode"}, mode, m);
      chk({req, " comm"}, comm_en, c);
      chk({req, " term"}, term_en, t);
      chk({req, " inh"}, inh_on, h);
   endtask

   task automatic to_normal();
      en_pin = 1'b1;
      step(ND);
   endtask

   task automatic to_sleep();
      en_pin = 1'b0;
      tx_level = 1'b1;
      step(SD);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      step(2);
      rst_n = 1'b1;
      step(1);
      // R1 reset state, R2 unpowered outputs
      chk("R1 mode", mode, 1);
      chk("R1 comm", comm_en, 0);
      chk("R1 flag", rx_wake_flag, 0);
      chk("R2 term unpowered", term_en, 0);

      // R2 inhibit delay after power
      pwr_ok = 1'b1;
      step(ID - 1);
      chk("R2 inh before delay", inh_on, 0);
      step(1);
      chk("R2 inh after delay", inh_on, 1);
      chk("R7 term in failsafe", term_en, 1);

      // R4 sweep of too-short enable holds
      for (int h = 1; h < ND; h++) begin
         en_pin = 1'b1;
         step(h);
         en_pin = 1'b0;
         step(1);
         chk("R4 short hold stays failsafe", mode, 1);
      end
      en_pin = 1'b1;
      step(ND - 1);
      chk("R4 before boundary", mode, 1);
      step(1);
      outs("R4 R7 R10 normal", 2, 1, 1, 1);

      // R5 enable low with transmit low does not arm
      tx_level = 1'b0;
      en_pin = 1'b0;
      step(SD + 2);
      chk("R5 no arm with tx low", mode, 2);

      // R5 sweep of cancelled sleep requests
      for (int h = 1; h < SD; h++) begin
         tx_level = 1'b1;
         en_pin = 1'b0;
         step(h);
         en_pin = 1'b1;
         step(1);
         chk("R5 cancelled request", mode, 2);
      end

      // R5 arm persists after transmit drops
      en_pin = 1'b0;
      tx_level = 1'b1;
      step(1);
      tx_level = 1'b0;
      step(SD - 2);
      chk("R5 before boundary", mode, 2);
      step(1);
      outs("R5 R7 R10 sleep", 0, 0, 0, 0);

      // R6 enable in sleep ignored
      en_pin = 1'b1;
      step(3);
      chk("R6 en ignored in sleep", mode, 0);
      en_pin = 1'b0;
      step(1);

      // R6 R8 R9 remote wake
      wake_rem_stb = 1'b1;
      step(1);
      wake_rem_stb = 1'b0;
      outs("R6 remote wake", 1, 0, 1, 1);
      chk("R8 flag set", rx_wake_flag, 1);
      chk("R9 remote source", tx_src_local, 0);
      step(3);
      chk("R8 flag held", rx_wake_flag, 1);
      en_pin = 1'b1;
      #1;
      chk("R8 flag cleared by en", rx_wake_flag, 0);
      step(ND);
      chk("R4 normal after wake", mode, 2);

      // R9 local wake
      to_sleep();
      chk("R5 sleep again", mode, 0);
      wake_loc_stb = 1'b1;
      step(1);
      wake_loc_stb = 1'b0;
      chk("R9 local source", tx_src_local, 1);
      chk("R8 flag local", rx_wake_flag, 1);
      en_pin = 1'b1;
      #1;
      chk("R9 source cleared by en", tx_src_local, 0);
      step(ND);

      // R9 both strobes, local first
      to_sleep();
      wake_loc_stb = 1'b1;
      wake_rem_stb = 1'b1;
      step(1);
      wake_loc_stb = 1'b0;
      wake_rem_stb = 1'b0;
      chk("R9 both strobes local", tx_src_local, 1);

      // R3 undervoltage in failsafe
      supply_uv = 1'b1;
      #1;
      chk("R3 inh off in uv failsafe", inh_on, 0);
      en_pin = 1'b1;
      step(ND + 2);
      chk("R3 no normal under uv", mode, 1);
      supply_uv = 1'b0;
      step(ND);
      chk("R4 normal after uv clears", mode, 2);

      // R3 undervoltage in normal
      supply_uv = 1'b1;
      #1;
      chk("R3 comm drops same cycle", comm_en, 0);
      step(1);
      chk("R3 normal to failsafe", mode, 1);
      supply_uv = 1'b0;
      step(ND);
      to_sleep();
      supply_uv = 1'b1;
      step(1);
      chk("R3 sleep to failsafe", mode, 1);
      supply_uv = 1'b0;

      // R2 power loss
      pwr_ok = 1'b0;
      step(1);
      outs("R2 power lost", 1, 0, 0, 0);
      chk("R2 flag cleared", rx_wake_flag, 0);
      pwr_ok = 1'b1;
      step(ID - 1);
      chk("R2 inh delay repeats", inh_on, 0);
      step(1);
      chk("R2 inh on again", inh_on, 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule